// File: doc/BRIEF.md
# Four-Channel Buffered Output Code Bank

This block holds the digital side of a four-channel, 12-bit output converter. A 16-bit register bus writes one code per channel into a shadow register, and writes a shared range word that selects gain and polarity for each channel. The block drives four latched 12-bit codes and the range flags currently in force to the converters, which sit outside it.

A two-bit control word sets whether outputs are enabled and whether updates are immediate or buffered. In immediate mode a code write reaches its output on the next clock. In buffered mode code writes collect in the shadows and all four outputs move together when the bus reads the control offset. Range writes are always staged: they take effect when the bus reads the range offset. This lets software prepare a full set of channels and ranges and then commit them with single read strobes, so that all channels switch in the same cycle.

Top module: `dac_bank`

## Requirements
- R1: A synchronous reset clears the control word, the staged and applied range words, all shadows and all output codes to zero.
- R2: The control word lives at byte offset 0x02, with bit 1 the output enable and bit 0 the buffered-mode select. `busRdData` returns it in bits 1:0 when `busAddr` is 0x02, returns the staged range word in bits 11:4 when `busAddr` is 0x12, and is zero in every other bit and at every other offset.
- R3: A code write keeps only bits 11:0 of `busWrData`; bits 15:12 have no effect on any output.
- R4: Channel x's code is written at byte offset 0x14 + 2x (x = 0..3); with output enable 1 and buffered select 0, the written code appears on that channel's output one clock later and the other channels keep their values.
- R5: With output enable 1 and buffered select 1, code writes change no output.
- R6: A bus read at offset 0x02 while output enable is 1 copies all four shadows to the outputs in the same clock.
- R7: While output enable is 0, every output code is zero from the next clock on, and code writes still update the shadows, which a later enable and commit read bring out.
- R8: A write at offset 0x12 changes no range output; a bus read at offset 0x12 applies the staged word one clock later.
- R9: In the applied range word, bit (7 − x) is channel x's bipolar flag and bit (11 − x) is channel x's gain flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 6 | Byte offset of the access |
| busWe | input | 1 | Write strobe, one cycle per access |
| busRe | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for the current offset |
| dacCode | output | 48 | Output codes, channel x in bits 12x+11:12x |
| rangeGain | output | 4 | Applied gain flag, bit x for channel x |
| rangeBipolar | output | 4 | Applied bipolar flag, bit x for channel x |

## Verification
Directed sequences take the bank through immediate mode, buffered mode with a single commit read, a disabled phase with writes landing in the shadows, and range words whose bit pattern separates the bipolar and gain positions of distinct channels, so a swapped bit order or a missing stage shows as a wrong flag. Writes with upper data bits set tell stored bits from ignored ones. A long random mix of control, range, code, odd-offset and commit accesses then stresses the ordering between mode changes and commits, where a model that updates from the control word in force before each edge tells a one-cycle-early or late mode change apart from correct behaviour.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 12;
  localparam int BUS_W = 16;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] CTL_OFS = 6'h02;
  localparam logic [ADDR_W-1:0] RANGE_OFS = 6'h12;
  localparam logic [ADDR_W-1:0] DATA_OFS = 6'h14;
  localparam int BIP_TOP = 7;
  localparam int GAIN_TOP = 11;
  localparam int RANGE_LO = BIP_TOP - NUM_CH + 1;
  localparam int RANGE_W = GAIN_TOP - RANGE_LO + 1;

  typedef struct packed {
    logic [NUM_CH-1:0] dataWe;
    logic ctlWe;
    logic rangeWe;
    logic rangeCommit;
    logic dataCommit;
  } strobe_t;
endpackage

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
  import dac_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [1:0]        ctlWrData,
  output strobe_t           strb,
  output logic              ctlEn,
  output logic              ctlBuf
);
  logic [NUM_CH-1:0] dataHit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign dataHit[i] = busWe && (busAddr == DATA_OFS + ADDR_W'(2 * i));
  end

  always_comb begin
    strb.dataWe      = dataHit;
    strb.ctlWe       = busWe && (busAddr == CTL_OFS);
    strb.rangeWe     = busWe && (busAddr == RANGE_OFS);
    strb.rangeCommit = busRe && (busAddr == RANGE_OFS);
    strb.dataCommit  = busRe && (busAddr == CTL_OFS);
  end

  // control word: enable and buffered select
  always_ff @(posedge clk) begin
    if (rst) begin
      ctlEn  <= 1'b0;
      ctlBuf <= 1'b0;
    end else if (strb.ctlWe) begin
      ctlEn  <= ctlWrData[1];
      ctlBuf <= ctlWrData[0];
    end
  end
endmodule

// File: rtl/dac_bank_dp.sv
module dac_bank_dp
  import dac_bank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  strb,
  input  logic                     ctlEn,
  input  logic                     ctlBuf,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [RANGE_W-1:0]       rangeWr,
  output logic [NUM_CH*DATA_W-1:0] dacCode,
  output logic [RANGE_W-1:0]       rangePend,
  output logic [NUM_CH-1:0]        rangeGain,
  output logic [NUM_CH-1:0]        rangeBipolar
);
  logic [DATA_W-1:0] shadowQ [NUM_CH];
  logic [DATA_W-1:0] latchQ  [NUM_CH];
  logic [RANGE_W-1:0] rangeApplied;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) shadowQ[i] <= '0;
      else if (strb.dataWe[i]) shadowQ[i] <= wrData;
    end

    // commit read outranks an immediate write in the same cycle
    always_ff @(posedge clk) begin
      if (rst || !ctlEn) latchQ[i] <= '0;
      else if (strb.dataCommit) latchQ[i] <= shadowQ[i];
      else if (strb.dataWe[i] && !ctlBuf) latchQ[i] <= wrData;
    end

    assign dacCode[i*DATA_W +: DATA_W] = latchQ[i];
    assign rangeBipolar[i] = rangeApplied[BIP_TOP - i - RANGE_LO];
    assign rangeGain[i]    = rangeApplied[GAIN_TOP - i - RANGE_LO];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rangePend    <= '0;
      rangeApplied <= '0;
    end else begin
      if (strb.rangeWe) rangePend <= rangeWr;
      if (strb.rangeCommit) rangeApplied <= rangePend;
    end
  end
endmodule

// File: rtl/dac_bank.sv
module dac_bank
  import dac_bank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWe,
  input  logic                     busRe,
  input  logic [BUS_W-1:0]         busWrData,
  output logic [BUS_W-1:0]         busRdData,
  output logic [NUM_CH*DATA_W-1:0] dacCode,
  output logic [NUM_CH-1:0]        rangeGain,
  output logic [NUM_CH-1:0]        rangeBipolar
);
  strobe_t strb;
  logic ctlEn;
  logic ctlBuf;
  logic [RANGE_W-1:0] rangePend;
  logic unusedWrHi;

  assign unusedWrHi = ^busWrData[BUS_W-1:GAIN_TOP+1];

  dac_bank_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busRe    (busRe),
    .ctlWrData(busWrData[1:0]),
    .strb     (strb),
    .ctlEn    (ctlEn),
    .ctlBuf   (ctlBuf)
  );

  dac_bank_dp u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .ctlEn       (ctlEn),
    .ctlBuf      (ctlBuf),
    .wrData      (busWrData[DATA_W-1:0]),
    .rangeWr     (busWrData[GAIN_TOP:RANGE_LO]),
    .dacCode     (dacCode),
    .rangePend   (rangePend),
    .rangeGain   (rangeGain),
    .rangeBipolar(rangeBipolar)
  );

  always_comb begin
    busRdData = '0;
    if (busAddr == CTL_OFS) busRdData = BUS_W'({ctlEn, ctlBuf});
    else if (busAddr == RANGE_OFS) busRdData = BUS_W'(rangePend) << RANGE_LO;
  end
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk
  import dac_bank_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic [ADDR_W-1:0]        busAddr,
  input logic                     busWe,
  input logic                     busRe,
  input logic [BUS_W-1:0]         busWrData,
  input logic [BUS_W-1:0]         busRdData,
  input logic [NUM_CH*DATA_W-1:0] dacCode,
  input logic [NUM_CH-1:0]        rangeGain,
  input logic [NUM_CH-1:0]        rangeBipolar,
  input logic                     ctlEn,
  input logic                     ctlBuf
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dacCode == '0 && rangeGain == '0 && rangeBipolar == '0));

  a_r2_ctl_read_narrow: assert property (@(posedge clk) disable iff (rst)
    (busAddr == CTL_OFS) |-> (busRdData[BUS_W-1:2] == '0));

  a_r4_immediate_write: assert property (@(posedge clk) disable iff (rst)
    (ctlEn && !ctlBuf && busWe && !busRe && busAddr == DATA_OFS)
      |=> (dacCode[DATA_W-1:0] == $past(busWrData[DATA_W-1:0])));

  a_r5_buffered_hold: assert property (@(posedge clk) disable iff (rst)
    (ctlEn && ctlBuf && !busWe && !(busRe && busAddr == CTL_OFS))
      |=> $stable(dacCode));

  a_r7_disabled_zero: assert property (@(posedge clk) disable iff (rst)
    !ctlEn |=> (dacCode == '0));

  a_r8_range_staged: assert property (@(posedge clk) disable iff (rst)
    !(busRe && busAddr == RANGE_OFS) |=> ($stable(rangeGain) && $stable(rangeBipolar)));
endmodule

bind dac_bank dac_bank_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .busRe       (busRe),
  .busWrData   (busWrData),
  .busRdData   (busRdData),
  .dacCode     (dacCode),
  .rangeGain   (rangeGain),
  .rangeBipolar(rangeBipolar),
  .ctlEn       (ctlEn),
  .ctlBuf      (ctlBuf)
);

// File: tb/tb_dac_bank.sv
`timescale 1ns/1ps
module tb_dac_bank;
  logic clk = 1'b0;
  logic rst;
  logic [5:0] busAddr;
  logic busWe, busRe;
  logic [15:0] busWrData;
  logic [15:0] busRdData;
  logic [47:0] dacCode;
  logic [3:0] rangeGain, rangeBipolar;

  int total = 0;
  int bad = 0;

  logic [11:0] expShadow [4];
  logic [11:0] expLatch [4];
  logic [15:0] expPend, expApplied;
  logic expEn, expBuf;

  always #10 clk = ~clk;

  dac_bank dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWrData(busWrData), .busRdData(busRdData), .dacCode(dacCode),
    .rangeGain(rangeGain), .rangeBipolar(rangeBipolar)
  );

  function automatic logic [47:0] packCodes();
    logic [47:0] v;
    for (int i = 0; i < 4; i++) v[i*12 +: 12] = expLatch[i];
    return v;
  endfunction

  // bipolar flag of channel x at bit 7-x, gain flag at bit 11-x
  function automatic logic [7:0] decodeRange(input logic [15:0] w);
    logic [7:0] v;
    for (int x = 0; x < 4; x++) begin
      v[x]     = w[7 - x];
      v[4 + x] = w[11 - x];
    end
    return v;
  endfunction

  function automatic logic [15:0] expRead(input logic [5:0] a);
    if (a == 6'h02) return {14'd0, expEn, expBuf};
    if (a == 6'h12) return expPend & 16'h0FF0;
    return 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string req);
    logic [47:0] ec;
    logic [7:0] er;
    ec = packCodes();
    er = decodeRange(expApplied);
    check(dacCode === ec, req, dacCode, ec);
    check({rangeGain, rangeBipolar} === er, req, {40'd0, rangeGain, rangeBipolar}, {40'd0, er});
  endtask

  task automatic modelStep(input bit we, input bit re, input logic [5:0] a, input logic [15:0] d);
    bit oldEn, oldBuf;
    oldEn = expEn;
    oldBuf = expBuf;
    if (re && a == 6'h02 && oldEn)
      for (int i = 0; i < 4; i++) expLatch[i] = expShadow[i];
    if (re && a == 6'h12) expApplied = expPend;
    if (we) begin
      if (a == 6'h02) begin
        expEn = d[1];
        expBuf = d[0];
      end
      if (a == 6'h12) expPend = d;
      for (int i = 0; i < 4; i++)
        if (a == 6'(8'h14 + 2 * i)) begin
          expShadow[i] = d[11:0];
          if (oldEn && !oldBuf) expLatch[i] = d[11:0];
        end
    end
    if (!oldEn)
      for (int i = 0; i < 4; i++) expLatch[i] = 12'd0;
  endtask

  task automatic doOp(input bit we, input bit re, input logic [5:0] a, input logic [15:0] d, input string req);
    busAddr = a; busWe = we; busRe = re; busWrData = d;
    #5;
    if (re) check(busRdData === expRead(a), "R2", {32'd0, busRdData}, {32'd0, expRead(a)});
    @(posedge clk);
    modelStep(we, re, a, d);
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0;
    checkOuts(req);
  endtask

  task automatic doReset();
    rst = 1'b1;
    busWe = 1'b0; busRe = 1'b0; busAddr = '0; busWrData = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      expShadow[i] = '0;
      expLatch[i] = '0;
    end
    expPend = '0; expApplied = '0; expEn = 1'b0; expBuf = 1'b0;
    checkOuts("R1");
  endtask

  initial begin
    #(20ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7041));
    doReset();
    doOp(1'b0, 1'b1, 6'h02, 16'h0, "R1");
    // immediate mode, upper data bits dropped
    doOp(1'b1, 1'b0, 6'h02, 16'hFFFE, "R2");
    doOp(1'b1, 1'b0, 6'h14, 16'hF123, "R3");
    doOp(1'b1, 1'b0, 6'h18, 16'h0ABC, "R4");
    doOp(1'b1, 1'b0, 6'h1A, 16'hA5A5, "R4");
    // buffered mode
    doOp(1'b1, 1'b0, 6'h02, 16'h0003, "R2");
    doOp(1'b1, 1'b0, 6'h16, 16'h0555, "R5");
    doOp(1'b1, 1'b0, 6'h14, 16'h0999, "R5");
    doOp(1'b0, 1'b1, 6'h02, 16'h0, "R6");
    // disabled: zero outputs, shadows still written
    doOp(1'b1, 1'b0, 6'h02, 16'h0001, "R7");
    doOp(1'b1, 1'b0, 6'h1A, 16'h0777, "R7");
    doOp(1'b0, 1'b1, 6'h02, 16'h0, "R7");
    doOp(1'b1, 1'b0, 6'h02, 16'h0003, "R7");
    doOp(1'b0, 1'b1, 6'h02, 16'h0, "R7");
    // range staging and bit mapping
    doOp(1'b1, 1'b0, 6'h12, 16'h0180, "R8");
    doOp(1'b0, 1'b1, 6'h12, 16'h0, "R9");
    doOp(1'b1, 1'b0, 6'h12, 16'hFFFF, "R8");
    doOp(1'b0, 1'b0, 6'h00, 16'h0, "R8");
    doOp(1'b0, 1'b1, 6'h12, 16'h0, "R9");
    doOp(1'b1, 1'b0, 6'h12, 16'h0A50, "R8");
    doOp(1'b0, 1'b1, 6'h12, 16'h0, "R9");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [5:0] a;
      int sel;
      bit isRead;
      sel = int'($urandom % 8);
      case (sel)
        0, 7: a = 6'h02;
        1: a = 6'h12;
        6: a = 6'($urandom);
        default: a = 6'(8'h14 + 2 * (sel - 2));
      endcase
      isRead = ($urandom % 3) == 0;
      doOp(!isRead, isRead, a, 16'($urandom), "R4/R5/R6/R7/R8");
    end
    doReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule